// File: doc/BRIEF.md
# Sampling Phase Tuning Sequencer

This block selects the receive sampling phase of a high-speed memory-card host. When software requests tuning, the sequencer first decides whether the current bus mode needs it. If it does not, it finishes at once with success. Otherwise it places the delay line under software control and steps its code across the full range. At each code it asks an external command engine to run one tuning-block transfer, and it records whether that transfer passed.

When the sweep is over, the block takes the longest run of consecutive passing codes. It programs a code three quarters of the way into that run, resets the data path and then the command path, and pulses done. If no code passed, or the tuned-clock status is not set, it drops delay-line control, asks for the clock select to be cleared, still resets both paths, and ends with the error flag raised. The delay line, the command engine and the path reset logic sit outside the block and are reached through request/acknowledge handshakes.

Top module: `phase_tune_seq`

## Requirements
- R1: `bus_mode_i` encodes 00 = legacy, 01 = SDR50, 10 = SDR104, 11 = HS200. Tuning runs only for HS200, for SDR104, or for SDR50 with `sdr50_tune_cap_i` high. In every other case the block pulses `done_o` with `err_o` low, with no calibration, no trial and no path reset.
- R2: When a sweep starts, `dl_override_o` and `dl_force_o` go high. They are high during every trial, and they stay high after a successful sequence.
- R3: The sweep makes 32 trials with delay codes 0, 4, 8, … 124, in rising order, exactly one trial per code.
- R4: Each code, including the final one, is presented on `dl_code_o` with force set. Then `dl_calib_o` rises and stays high, with the code stable, until `dl_calib_rb_i` is seen high, after which it drops. A trial starts only after calibrate has dropped.
- R5: If the readback never comes, `dl_calib_o` drops after exactly 1000 cycles and the sequence continues.
- R6: A passing trial after a failing one, or on the first trial, opens a run at that code. The longest run wins, and the earliest wins a tie. The final code is start + 4·floor(3·length/4).
- R7: On success the final code is calibrated. Then a data-path reset (`path_rst_sel_o` = 0) is requested, followed by a command-path reset (`path_rst_sel_o` = 1). Then `done_o` pulses with `err_o` low.
- R8: If no trial passes, `err_o` is set, `dl_override_o` and `dl_force_o` clear, and `clksel_clr_o` pulses once. Both path resets still run, in the same order, and no final code is calibrated.
- R9: If `tuned_clk_sel_i` is low after the sweep, the block takes the same error path as R8, even when trials passed.
- R10: A `start_i` pulse while a sequence is running is ignored. The sweep continues unchanged and only one `done_o` pulse results.
- R11: `done_o` is a single-cycle pulse. `err_o` holds its value until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Tuning request pulse |
| bus_mode_i | input | 2 | Active bus mode (see R1) |
| sdr50_tune_cap_i | input | 1 | SDR50 requires tuning |
| tuned_clk_sel_i | input | 1 | Tuned sampling clock is selected |
| dl_override_o | output | 1 | Delay line under software control |
| dl_force_o | output | 1 | Forced code enable |
| dl_code_o | output | 7 | Forced delay code |
| dl_calib_o | output | 1 | Calibrate request |
| dl_calib_rb_i | input | 1 | Calibrate readback |
| trial_req_o | output | 1 | Tuning-block transfer request |
| trial_ack_i | input | 1 | Transfer finished |
| trial_pass_i | input | 1 | Transfer result, valid with ack |
| clksel_clr_o | output | 1 | Pulse: clear the clock select |
| path_rst_req_o | output | 1 | Path reset request |
| path_rst_sel_o | output | 1 | 0 = data path, 1 = command path |
| path_rst_ack_i | input | 1 | Path reset finished |
| done_o | output | 1 | Sequence finished pulse |
| err_o | output | 1 | Tuning failed |

## Verification
The embedded assertions check ordering properties on every cycle. They confirm that trials run only with the delay line overridden and forced, that calibrate is only raised under force and holds its code steady, that the code advances by one step after each trial, that a path-reset sequence always opens on the data path, and that done lasts one cycle. Some results depend on the whole pass/fail history, and only the bench scenarios can show them: the chosen window and the final code, tie resolution, the error outcomes, the calibrate timeout length, and the rejection of a second start. The bench computes these from its own scan of the pass pattern.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;

    typedef enum logic [1:0] {
        MODE_LEGACY = 2'b00,
        MODE_SDR50  = 2'b01,
        MODE_SDR104 = 2'b10,
        MODE_HS200  = 2'b11
    } bus_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CAL,
        ST_TRIAL,
        ST_CHECK,
        ST_RST_DATA,
        ST_RST_CMD,
        ST_FINISH
    } seq_state_e;

    function automatic logic needs_tuning(bus_mode_e mode, logic sdr50_cap);
        return (mode == MODE_HS200) || (mode == MODE_SDR104) ||
               ((mode == MODE_SDR50) && sdr50_cap);
    endfunction

endpackage

// File: rtl/phase_cal_ctrl.sv
module phase_cal_ctrl #(
    parameter int POLL_MAX = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic rb_i,
    output logic calib_o,
    output logic fin_o
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    logic [POLL_W-1:0] poll_cnt;

    assign calib_o = en_i;
    assign fin_o   = en_i && (rb_i || (poll_cnt == POLL_W'(POLL_MAX - 1)));

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            poll_cnt <= '0;
        end else if (!fin_o) begin
            poll_cnt <= poll_cnt + 1'b1;
        end
    end

    // R4
    cal_release_chk: assert property (@(posedge clk) disable iff (rst)
        fin_o |=> !en_i);

endmodule

// File: rtl/phase_window_track.sv
module phase_window_track #(
    parameter int CODE_W = 7,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              upd_i,
    input  logic              pass_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] best_start_o,
    output logic [LEN_W-1:0]  best_len_o
);
    logic              prev_pass;
    logic [CODE_W-1:0] run_start, run_start_n;
    logic [LEN_W-1:0]  run_len, run_len_n;

    always_comb begin
        run_start_n = run_start;
        run_len_n   = '0;
        if (pass_i) begin
            if (prev_pass) begin
                run_len_n = run_len + 1'b1;
            end else begin
                run_start_n = code_i;
                run_len_n   = LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            prev_pass    <= 1'b0;
            run_start    <= '0;
            run_len      <= '0;
            best_start_o <= '0;
            best_len_o   <= '0;
        end else if (upd_i) begin
            prev_pass <= pass_i;
            run_start <= run_start_n;
            run_len   <= run_len_n;
            if (run_len_n > best_len_o) begin
                best_start_o <= run_start_n;
                best_len_o   <= run_len_n;
            end
        end
    end

    // R6
    best_len_mono_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> best_len_o >= $past(best_len_o));

endmodule

// File: rtl/phase_tune_seq.sv
module phase_tune_seq
    import phase_tune_pkg::*;
#(
    parameter int CODE_W    = 7,
    parameter int STEP      = 4,
    parameter int LAST_CODE = 124,
    parameter int POLL_MAX  = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        bus_mode_i,
    input  logic              sdr50_tune_cap_i,
    input  logic              tuned_clk_sel_i,
    output logic              dl_override_o,
    output logic              dl_force_o,
    output logic [CODE_W-1:0] dl_code_o,
    output logic              dl_calib_o,
    input  logic              dl_calib_rb_i,
    output logic              trial_req_o,
    input  logic              trial_ack_i,
    input  logic              trial_pass_i,
    output logic              clksel_clr_o,
    output logic              path_rst_req_o,
    output logic              path_rst_sel_o,
    input  logic              path_rst_ack_i,
    output logic              done_o,
    output logic              err_o
);
    localparam int NTRIALS = LAST_CODE / STEP + 1;
    localparam int LEN_W   = $clog2(NTRIALS + 1);
    localparam int CW      = CODE_W + LEN_W + 4;

    seq_state_e        state;
    logic              final_q;
    logic              cal_fin;
    logic              win_clear;
    logic              win_upd;
    logic              tune_fail;
    logic [CODE_W-1:0] best_start;
    logic [LEN_W-1:0]  best_len;
    logic [CW-1:0]     three_len;
    logic [CW-1:0]     fin_wide;
    logic [CODE_W-1:0] final_code;

    assign win_clear = (state == ST_IDLE) && start_i;
    assign win_upd   = (state == ST_TRIAL) && trial_ack_i;
    assign tune_fail = (best_len == '0) || !tuned_clk_sel_i;

    assign three_len  = CW'(best_len) * CW'(3);
    assign fin_wide   = CW'(best_start) + CW'(STEP) * (three_len / CW'(4));
    assign final_code = fin_wide[CODE_W-1:0];

    phase_cal_ctrl #(.POLL_MAX(POLL_MAX)) u_cal (
        .clk     (clk),
        .rst     (rst),
        .en_i    (state == ST_CAL),
        .rb_i    (dl_calib_rb_i),
        .calib_o (dl_calib_o),
        .fin_o   (cal_fin)
    );

    phase_window_track #(.CODE_W(CODE_W), .LEN_W(LEN_W)) u_win (
        .clk          (clk),
        .rst          (rst),
        .clear_i      (win_clear),
        .upd_i        (win_upd),
        .pass_i       (trial_pass_i),
        .code_i       (dl_code_o),
        .best_start_o (best_start),
        .best_len_o   (best_len)
    );

    assign trial_req_o    = (state == ST_TRIAL);
    assign path_rst_req_o = (state == ST_RST_DATA) || (state == ST_RST_CMD);
    assign path_rst_sel_o = (state == ST_RST_CMD);
    assign done_o         = (state == ST_FINISH);
    assign clksel_clr_o   = (state == ST_CHECK) && tune_fail;

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            final_q       <= 1'b0;
            dl_override_o <= 1'b0;
            dl_force_o    <= 1'b0;
            dl_code_o     <= '0;
            err_o         <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    err_o   <= 1'b0;
                    final_q <= 1'b0;
                    if (needs_tuning(bus_mode_e'(bus_mode_i), sdr50_tune_cap_i)) begin
                        dl_override_o <= 1'b1;
                        dl_force_o    <= 1'b1;
                        dl_code_o     <= '0;
                        state         <= ST_CAL;
                    end else begin
                        state <= ST_FINISH;
                    end
                end
                ST_CAL: if (cal_fin) begin
                    state <= final_q ? ST_RST_DATA : ST_TRIAL;
                end
                ST_TRIAL: if (trial_ack_i) begin
                    if (dl_code_o == CODE_W'(LAST_CODE)) begin
                        state <= ST_CHECK;
                    end else begin
                        dl_code_o <= dl_code_o + CODE_W'(STEP);
                        state     <= ST_CAL;
                    end
                end
                ST_CHECK: begin
                    if (tune_fail) begin
                        err_o         <= 1'b1;
                        dl_override_o <= 1'b0;
                        dl_force_o    <= 1'b0;
                        state         <= ST_RST_DATA;
                    end else begin
                        dl_code_o <= final_code;
                        final_q   <= 1'b1;
                        state     <= ST_CAL;
                    end
                end
                ST_RST_DATA: if (path_rst_ack_i) state <= ST_RST_CMD;
                ST_RST_CMD:  if (path_rst_ack_i) state <= ST_FINISH;
                ST_FINISH:   state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // R2
    trial_under_override_chk: assert property (@(posedge clk) disable iff (rst)
        trial_req_o |-> (dl_override_o && dl_force_o));

    // R4
    calib_needs_force_chk: assert property (@(posedge clk) disable iff (rst)
        dl_calib_o |-> dl_force_o);

    // R4
    calib_code_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (dl_calib_o && $past(dl_calib_o)) |-> $stable(dl_code_o));

    // R3
    code_step_chk: assert property (@(posedge clk) disable iff (rst)
        (trial_req_o && trial_ack_i && dl_code_o != CODE_W'(LAST_CODE))
        |=> dl_code_o == $past(dl_code_o) + CODE_W'(STEP));

    // R7
    data_reset_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(path_rst_req_o) |-> !path_rst_sel_o);

    // R10
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (trial_req_o && start_i && !trial_ack_i) |=> trial_req_o);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: tb/phase_tune_seq_tb.sv
module phase_tune_seq_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [1:0] bus_mode_i = 2'b00;
    logic       sdr50_tune_cap_i = 1'b0;
    logic       tuned_clk_sel_i = 1'b1;
    logic       dl_override_o, dl_force_o, dl_calib_o;
    logic [6:0] dl_code_o;
    logic       dl_calib_rb_i = 1'b0;
    logic       trial_req_o;
    logic       trial_ack_i = 1'b0;
    logic       trial_pass_i = 1'b0;
    logic       clksel_clr_o, path_rst_req_o, path_rst_sel_o;
    logic       path_rst_ack_i = 1'b0;
    logic       done_o, err_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [31:0] pattern = '0;
    logic        rb_block = 1'b0;
    int          trial_codes[$];
    int          cal_codes[$];
    int          cal_runs[$];
    int          rst_seq[$];
    int          clr_cnt = 0;
    int          done_cnt = 0;
    logic        err_at_done = 1'b0;
    int          cur_run = 0;
    logic        prev_calib = 1'b0;

    always #2 clk = ~clk;

    phase_tune_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .bus_mode_i(bus_mode_i),
        .sdr50_tune_cap_i(sdr50_tune_cap_i), .tuned_clk_sel_i(tuned_clk_sel_i),
        .dl_override_o(dl_override_o), .dl_force_o(dl_force_o),
        .dl_code_o(dl_code_o), .dl_calib_o(dl_calib_o), .dl_calib_rb_i(dl_calib_rb_i),
        .trial_req_o(trial_req_o), .trial_ack_i(trial_ack_i), .trial_pass_i(trial_pass_i),
        .clksel_clr_o(clksel_clr_o), .path_rst_req_o(path_rst_req_o),
        .path_rst_sel_o(path_rst_sel_o), .path_rst_ack_i(path_rst_ack_i),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Responders and monitor, all acting at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=0", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
            dl_calib_rb_i = rb_block ? 1'b0 : dl_calib_o;
            if (dl_calib_o) begin
                if (!prev_calib) begin
                    cal_codes.push_back(int'(dl_code_o));
                    cur_run = 0;
                end
                cur_run++;
            end else if (prev_calib) begin
                cal_runs.push_back(cur_run);
            end
            prev_calib = dl_calib_o;
            if (trial_ack_i) begin
                trial_ack_i = 1'b0;
            end else if (trial_req_o) begin
                // R3: codes step by 4 from 0 in order; R4: no trial during calibrate; R2: override held
                chk("R3 trial code", int'(dl_code_o), 4 * trial_codes.size());
                chk("R4 calib low in trial", int'(dl_calib_o), 0);
                chk("R2 override+force in trial", int'(dl_override_o && dl_force_o), 1);
                trial_pass_i = pattern[trial_codes.size() % 32];
                trial_codes.push_back(int'(dl_code_o));
                trial_ack_i = 1'b1;
            end
            if (path_rst_ack_i) begin
                path_rst_ack_i = 1'b0;
            end else if (path_rst_req_o) begin
                rst_seq.push_back(int'(path_rst_sel_o));
                path_rst_ack_i = 1'b1;
            end
            if (clksel_clr_o) clr_cnt++;
            if (done_o) begin
                done_cnt++;
                err_at_done = err_o;
            end
        end
    end

    task automatic expect_window(input logic [31:0] pat, output int bs, output int bl);
        int rs = 0;
        int rl = 0;
        bs = 0;
        bl = 0;
        for (int i = 0; i < 32; i++) begin
            if (pat[i]) begin
                if (rl == 0) rs = i;
                rl++;
                if (rl > bl) begin
                    bl = rl;
                    bs = rs;
                end
            end else begin
                rl = 0;
            end
        end
    endtask

    task automatic run_case(input string tag, input logic [1:0] mode, input logic cap,
                            input logic csel, input logic [31:0] pat,
                            input logic tuned, input int extra_start_at);
        int bs, bl, fin, n;
        logic fail_path;
        trial_codes.delete();
        cal_codes.delete();
        cal_runs.delete();
        rst_seq.delete();
        clr_cnt = 0;
        done_cnt = 0;
        pattern = pat;
        bus_mode_i = mode;
        sdr50_tune_cap_i = cap;
        tuned_clk_sel_i = csel;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (done_cnt == 0) begin
            @(negedge clk);
            n++;
            if (extra_start_at > 0 && n == extra_start_at) start_i = 1'b1;
            else start_i = 1'b0;
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " R11 single done"}, done_cnt, 1);
        if (!tuned) begin
            chk({tag, " R1 no trials"}, trial_codes.size(), 0);
            chk({tag, " R1 no calibrate"}, cal_codes.size(), 0);
            chk({tag, " R1 no path reset"}, rst_seq.size(), 0);
            chk({tag, " R1 err low"}, int'(err_at_done), 0);
            return;
        end
        expect_window(pat, bs, bl);
        fin = bs * 4 + 4 * ((3 * bl) / 4);
        fail_path = (bl == 0) || !csel;
        chk({tag, " R3 trial count"}, trial_codes.size(), 32);
        chk({tag, " R7 reset count"}, rst_seq.size(), 2);
        if (rst_seq.size() == 2) begin
            chk({tag, " R7 data reset first"}, rst_seq[0], 0);
            chk({tag, " R7 command reset second"}, rst_seq[1], 1);
        end
        if (fail_path) begin
            // R8 / R9 error path
            chk({tag, " err set"}, int'(err_at_done), 1);
            chk({tag, " clksel clear pulse"}, clr_cnt, 1);
            chk({tag, " override dropped"}, int'(dl_override_o), 0);
            chk({tag, " force dropped"}, int'(dl_force_o), 0);
            chk({tag, " no final calibrate"}, cal_codes.size(), 32);
            chk({tag, " R11 err held"}, int'(err_o), 1);
        end else begin
            chk({tag, " R7 err low"}, int'(err_at_done), 0);
            chk({tag, " R7 final calibrated"}, cal_codes.size(), 33);
            if (cal_codes.size() == 33)
                chk({tag, " R6 final code"}, cal_codes[32], fin);
            chk({tag, " R2 override kept"}, int'(dl_override_o), 1);
            chk({tag, " R8 no clksel clear"}, clr_cnt, 0);
        end
    endtask

    initial begin
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset done", int'(done_o), 0);
        chk("reset err", int'(err_o), 0);
        chk("reset override", int'(dl_override_o), 0);
        chk("reset trial req", int'(trial_req_o), 0);
        chk("reset calib", int'(dl_calib_o), 0);

        // R1: modes without tuning
        run_case("legacy", 2'b00, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 0);
        run_case("sdr50 nocap", 2'b01, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 0);

        // R6: window of 8 at index 10 -> start 40, final 64; R4 fast readback
        run_case("hs200", 2'b11, 1'b0, 1'b1, 32'h0003_FC38, 1'b1, 0);
        bad = 0;
        foreach (cal_runs[i]) if (cal_runs[i] != 1) bad++;
        chk("R4 calib drops after readback", bad, 0);

        // R6 tie: two runs of 4, earliest (index 2) wins -> final 20
        run_case("sdr50 tie", 2'b01, 1'b1, 1'b1, 32'h00F0_003C, 1'b1, 0);
        // R6 all pass -> final 96
        run_case("sdr104 all", 2'b10, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, 0);
        // R6 single pass at last code -> final 124
        run_case("last only", 2'b11, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 0);

        // R8: nothing passes
        run_case("R8 no pass", 2'b11, 1'b0, 1'b1, 32'h0000_0000, 1'b1, 0);
        repeat (5) @(negedge clk);
        chk("R11 err still held", int'(err_o), 1);
        // R11: next accepted start clears err
        run_case("after err", 2'b00, 1'b0, 1'b1, 32'h0, 1'b0, 0);

        // R9: clock select not set
        run_case("R9 no clksel", 2'b10, 1'b0, 1'b0, 32'h0000_0FF0, 1'b1, 0);

        // R10: second start mid-sweep is ignored
        run_case("R10 restart", 2'b11, 1'b0, 1'b1, 32'h0F0F_0F0F, 1'b1, 20);

        // R5: readback never arrives
        rb_block = 1'b1;
        run_case("R5 timeout", 2'b11, 1'b0, 1'b1, 32'h0000_FF00, 1'b1, 0);
        bad = 0;
        foreach (cal_runs[i]) if (cal_runs[i] != 1000) bad++;
        chk("R5 calib window 1000", bad, 0);
        chk("R5 calib count", cal_runs.size(), 33);
        rb_block = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule